// File: doc/BRIEF.md
# Multichannel Periodic Pulse Sampler

This block takes a wide bank of already conditioned pulse lines, one bit per channel, where an active line reads as 1 and an idle line reads as 0. On every tick of a periodic timebase it captures all channels at once into an internal snapshot. It then raises an interrupt toward a small microcontroller, which reads the snapshot back one byte at a time over a simple parallel register bus. The timebase comes from the main clock through a divider. The default division of 6000 turns a 6 MHz clock into a 1 ms tick.

Every channel first passes through a two-stage synchronizer. The snapshot therefore reflects the input levels two clocks before the capturing edge. A control register gates the whole sampler: while its enable bit is clear, the divider is held at zero and no capture or interrupt takes place. The interrupt stays pending until the processor either writes the acknowledge address or reads the last snapshot byte. A tick that arrives while an interrupt is still pending sets a sticky overrun flag.

Top module: `pulse_snapshot_sampler`

## Requirements
- R1: After reset the interrupt is low, the control register reads 0, the status register reads 0 and every snapshot byte reads 0.
- R2: While enabled, a tick occurs every TICK_DIV clocks. The first tick falls TICK_DIV clocks after the edge that wrote the enable bit, and the interrupt output is high from the edge of each tick onward.
- R3: While control bit 0 is clear, the divider is held at zero: no tick occurs, the interrupt stays low and the snapshot does not change. Re-enabling restarts a full TICK_DIV period.
- R4: All channels are captured on the same tick edge, and the snapshot holds its value until the next tick whatever the inputs do in between.
- R5: Addresses 0 to NUM_BYTES-1 read snapshot bytes. Byte k bit j is channel 8k+j, so bit 0 of address 0 is channel 0. An active channel reads 1.
- R6: An input level must be present before the edge two clocks ahead of the tick edge to be captured. A level applied one clock later misses that tick.
- R7: The interrupt stays high until a write to address NUM_BYTES+2 (acknowledge, any data) or a read of address NUM_BYTES-1. Reads of other snapshot bytes leave it set.
- R8: A tick while the interrupt is pending, with no clearing access in that cycle, sets status bit 1 (overrun). Only an acknowledge write clears it. Status bit 0 mirrors the pending interrupt, and status is at address NUM_BYTES+1.
- R9: When a clearing access and a tick fall in the same cycle, the tick wins: the interrupt stays high and no overrun is recorded. A last-byte read in that cycle returns the previous snapshot.
- R10: The control register at address NUM_BYTES reads back the full byte written; bit 0 is the enable. Writes to snapshot or status addresses are ignored, and unmapped reads return 0.
- R11: Read data is registered: it appears on bus_rdata from the clock edge on which bus_cs and bus_rd are sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | NUM_CH | Conditioned pulse lines, 1 = active |
| bus_cs | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Snapshot-ready interrupt, level high |

## Verification
The case that decides correctness is a tick landing on the same edge as the processor clearing the interrupt, either through an acknowledge write or through a read of the last snapshot byte. The bench counts clocks from the enabling write, so it knows every tick edge exactly. It places each clearing strobe on a tick edge and then expects the interrupt still high, a status readback showing no overrun, and the last-byte read returning the byte captured on the tick before. A separate pass leaves a tick unacknowledged so the overrun path is seen set and cleared.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int BYTE_W       = 8;
    localparam int CTRL_EN_BIT  = 0;
    localparam int STAT_IRQ_BIT = 0;
    localparam int STAT_OVR_BIT = 1;

    function automatic int bytes_for(input int nbits);
        return (nbits + BYTE_W - 1) / BYTE_W;
    endfunction
endpackage

// File: rtl/pss_tick_gen.sv
module pss_tick_gen #(
    parameter int TICK_DIV = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a disabled divider sits at zero on the following cycle
    a_r3_held_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/pss_sync.sv
module pss_sync #(
    parameter int W      = 80,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pulse_snapshot_sampler.sv
module pulse_snapshot_sampler #(
    parameter int NUM_CH   = 80,
    parameter int TICK_DIV = 6000,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pulse_in,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    import pss_pkg::*;

    localparam int NUM_BYTES = bytes_for(NUM_CH);
    localparam int SNAP_W    = NUM_BYTES * BYTE_W;
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_BYTES - 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_BYTES);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(NUM_BYTES + 2);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [SNAP_W-1:0] snap;
        logic [7:0]        ctrl;
        logic              irq;
        logic              ovr;
        logic [7:0]        rdata;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_CH-1:0] sync_q;
    logic tick, rd_hit, wr_hit, ack_wr, last_rd, clr;
    logic [7:0] rd_val;

    pss_sync #(.W(NUM_CH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pulse_in), .q(sync_q)
    );

    pss_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(st_q.ctrl[CTRL_EN_BIT]), .tick(tick)
    );

    always_comb begin
        rd_hit  = bus_cs && bus_rd;
        wr_hit  = bus_cs && bus_wr;
        ack_wr  = wr_hit && (bus_addr == A_ACK);
        last_rd = rd_hit && (bus_addr == A_LAST);
        clr     = ack_wr || last_rd;

        rd_val = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (bus_addr == ADDR_W'(k))
                rd_val = st_q.snap[k*BYTE_W +: BYTE_W];
        end
        if (bus_addr == A_CTRL)
            rd_val = st_q.ctrl;
        if (bus_addr == A_STAT) begin
            rd_val[STAT_IRQ_BIT] = st_q.irq;
            rd_val[STAT_OVR_BIT] = st_q.ovr;
        end

        st_d = st_q;
        if (rd_hit)
            st_d.rdata = rd_val;
        if (wr_hit && bus_addr == A_CTRL)
            st_d.ctrl = bus_wdata;
        if (tick)
            st_d.snap = SNAP_W'(sync_q);

        if (tick)
            st_d.irq = 1'b1;
        else if (clr)
            st_d.irq = 1'b0;

        if (ack_wr)
            st_d.ovr = 1'b0;
        if (tick && st_q.irq && !clr)
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = st_q.irq;

    // Observer of tick spacing, kept apart from the divider
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        gap_q <= '0;
        else if (!st_q.ctrl[CTRL_EN_BIT])  gap_q <= '0;
        else if (tick)                     gap_q <= '0;
        else                               gap_q <= gap_q + 1'b1;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == CNT_W'(TICK_DIV - 1)));
    a_r7_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> irq);
    a_r4_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.snap));
    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl[CTRL_EN_BIT] |-> !tick);
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && irq && !clr) |=> st_q.ovr);
    a_r9_clear_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr || (clr && !st_q.ovr)) |=> !st_q.ovr);
    a_r11_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(bus_rdata));
endmodule

// File: tb/tb_pulse_snapshot_sampler.sv
module tb_pulse_snapshot_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 80;
    localparam int DIV  = 64;
    localparam int NB   = 10;
    localparam int A_CTRL = NB, A_STAT = NB + 1, A_ACK = NB + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] pins = '0;
    logic cs = 0, rd = 0, wr = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq;

    int total = 0, bad = 0, cyc = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) rd_seen <= cs & rd;

    pulse_snapshot_sampler #(.NUM_CH(NCH), .TICK_DIV(DIV), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pins), .bus_cs(cs), .bus_rd(rd),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq(irq)
    );

    // Monitor: pops one expected byte per completed read
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            total++;
            if (rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
            end
        end
    end

    function automatic logic [NCH-1:0] pat(input int seed);
        logic [NCH-1:0] r;
        for (int k = 0; k < NB; k++) r[k*8 +: 8] = 8'(seed * (k + 3) * 29 + k * 7);
        return r;
    endfunction

    task automatic check_irq(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        cs = 1; wr = 1; addr = 4'(a); wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic bus_read(input int a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        cs = 1; rd = 1; addr = 4'(a);
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic read_all(input logic [NCH-1:0] p, input string t);
        for (int k = 0; k < NB; k++) bus_read(k, p[k*8 +: 8], t);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int w, t2, t3, t4, t5, t6, t7, w2;
        logic [NCH-1:0] p1, pa, pb, pc, pd;
        p1 = pat(3); pa = pat(5); pb = pat(7); pc = pat(11); pd = pat(13);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_irq(1'b0, "R1 reset irq");
        bus_read(A_STAT, 8'h00, "R1 reset status");
        bus_read(A_CTRL, 8'h00, "R1 reset ctrl");
        read_all('0, "R1 reset snapshot");

        pins = p1;
        repeat (3 * DIV) @(negedge clk);
        check_irq(1'b0, "R3 disabled no irq");
        read_all('0, "R3 disabled snapshot unchanged");

        bus_write(A_CTRL, 8'hA5);       // enable bit 0 = 1, other bits stored
        w = cyc;
        bus_read(A_CTRL, 8'hA5, "R10 ctrl readback");
        bus_write(3, 8'hFF);            // ignored: snapshot address
        bus_write(A_STAT, 8'hFF);       // ignored: status address
        bus_read(14, 8'h00, "R10 unmapped read");
        wait_cyc(w + DIV - 1);
        check_irq(1'b0, "R2 no early tick");
        @(negedge clk);
        check_irq(1'b1, "R2 first tick at TICK_DIV");
        pins = pb;                      // must not disturb held snapshot
        bus_read(A_STAT, 8'h01, "R8 status irq only");
        bus_read(0, p1[7:0], "R5 byte0 channel order");
        check_irq(1'b1, "R7 non-last read keeps irq");
        read_all(p1, "R4 R5 coherent snapshot");
        check_irq(1'b0, "R7 last byte read clears irq");
        bus_read(3, p1[31:24], "R10 write to snapshot ignored");
        bus_read(A_STAT, 8'h00, "R10 write to status ignored");

        t2 = w + 2 * DIV;
        wait_cyc(t2 - 3); pins = pa;
        @(negedge clk);   pins = pb;    // one clock too late
        wait_cyc(t2 - 1);
        check_irq(1'b0, "R2 no irq before second tick");
        @(negedge clk);
        check_irq(1'b1, "R2 second tick period");
        bus_write(A_ACK, 8'h00);
        check_irq(1'b0, "R7 ack clears irq");
        read_all(pa, "R6 two-stage capture window");

        t3 = w + 3 * DIV; t4 = w + 4 * DIV;
        wait_cyc(t4 + 1);
        bus_read(A_STAT, 8'h03, "R8 overrun set");
        bus_read(A_STAT, 8'h03, "R8 overrun sticky");
        bus_write(A_ACK, 8'h00);
        bus_read(A_STAT, 8'h00, "R8 ack clears overrun");

        t5 = w + 5 * DIV; t6 = w + 6 * DIV; t7 = w + 7 * DIV;
        wait_cyc(t5 + 1);
        check_irq(1'b1, "R7 pending before coincident ack");
        pins = pc;
        wait_cyc(t6 - 1);
        bus_write(A_ACK, 8'h00);        // lands on the tick edge
        check_irq(1'b1, "R9 tick wins over ack");
        bus_read(A_STAT, 8'h01, "R9 no overrun on coincident ack");
        pins = pd;
        wait_cyc(t7 - 1);
        bus_read(NB - 1, pc[79:72], "R9 last read returns prior snapshot");
        check_irq(1'b1, "R9 tick wins over last read");
        bus_read(A_STAT, 8'h01, "R9 no overrun on coincident read");
        bus_read(NB - 1, pd[79:72], "R4 new snapshot after tick");
        check_irq(1'b0, "R7 last read clears irq");

        bus_write(A_CTRL, 8'h00);
        pins = pa;
        repeat (3 * DIV) @(negedge clk);
        check_irq(1'b0, "R3 no irq while off");
        read_all(pd, "R3 snapshot frozen while off");
        bus_write(A_CTRL, 8'h01);
        w2 = cyc;
        wait_cyc(w2 + DIV - 1);
        check_irq(1'b0, "R3 restart full period");
        @(negedge clk);
        check_irq(1'b1, "R3 tick after re-enable");
        read_all(pa, "R4 capture after re-enable");
        repeat (3) @(negedge clk);
        if (t3 < 0) $display("unused");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule